// File: doc/BRIEF.md
# Board Control Port Strobe Sequencer

This block drives the control register of a small external latch that holds board-level settings such as termination enables. A write walks that register through four timed steps, so the external logic sees chip-select and strobe edges around a stable data byte. A read raises a read enable for one timed step, captures the byte the latch returns, and then clears the register to zero. The order of strobe and chip-select edges depends on which of three chip variants is selected by a static input. On the dual-channel variant the chip-select also depends on which channel is in use.

The port register is `DATA_W + 5` bits wide. Bits `[DATA_W-1:0]` carry data. The control bits sit above them: legacy strobe at bit `DATA_W`, chip-select at `DATA_W+1`, read enable at `DATA_W+2`, the ultra2 strobe at `DATA_W+3` and the ultra2 read enable at `DATA_W+4`. Each step lasts `step_cycles` clocks, and a value of zero counts as one. The variant, channel, data byte and step length are captured when an operation starts. Requests that arrive while an operation is running are dropped.

The state machine has six states:
- ST_IDLE waits for a request. A write request goes to ST_W1, and a read request goes to ST_RD. If both arrive together, the write wins.
- A write moves ST_W1 → ST_W2 → ST_W3 → ST_W4, advancing at the end of each step.
- ST_W4 returns to ST_IDLE at the end of its step.
- ST_RD returns to ST_IDLE at the end of its step.

Top module: `bctl_seq`

## Requirements
- R1: After reset, `port_q`, `rd_data`, `done` and `busy` are all zero.
- R2: A write on the legacy variant (`variant` 0) drives four steps. Each step sets the port register to a new value:
  - step 1: strobe and chip-select;
  - step 2: strobe, chip-select and data;
  - step 3: chip-select and data;
  - step 4: data only.
- R3: A write on the dual-channel variant (`variant` 1) follows the same four steps as the legacy variant. The difference is that chip-select is present only when `chan_b` is 1.
- R4: A write on the ultra2 variant (`variant` 2) drives four steps:
  - step 1: all zeros;
  - step 2: data;
  - step 3: data and the ultra2 strobe (bit `DATA_W+3`);
  - step 4: all zeros.
  
  The legacy strobe and chip-select are never set during this write.
- R5: The read step drives a different value per variant:
  - legacy: read enable and chip-select;
  - ultra2: the ultra2 read enable only;
  - dual-channel: read enable, plus chip-select only when `chan_b` is 1.
- R6: A read samples `port_in` on the last clock of its read step into `rd_data`. In the same edge it clears `port_q` to zero. `rd_data` then holds until the next read completes.
- R7: Every step lasts `step_cycles` clocks, and a `step_cycles` of 0 lasts one clock.
- R8: `busy` is high while an operation runs. `done` is a one-clock pulse in the first idle cycle after the operation, and `busy` is low in that cycle.
- R9: Requests made while `busy` is high are ignored. Changes to `variant`, `chan_b`, `wr_data` or `step_cycles` after the start do not affect the running operation.
- R10: When `wr_req` and `rd_req` arrive together, the write is performed. `variant` code 3 behaves as the legacy variant.
- R11: After a write completes, `port_q` keeps its step-4 value until the next operation starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_req | input | 1 | Start a write sequence (sampled when idle) |
| rd_req | input | 1 | Start a read sequence (sampled when idle) |
| wr_data | input | DATA_W | Byte to write |
| variant | input | 2 | 0 legacy, 1 dual-channel, 2 ultra2, 3 legacy |
| chan_b | input | 1 | Channel B in use (dual-channel chip-select) |
| step_cycles | input | STEP_W | Clocks per step, 0 treated as 1 |
| port_in | input | DATA_W | Byte returned by the external latch |
| port_q | output | DATA_W+5 | Port register value |
| rd_data | output | DATA_W | Last captured read byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |

## Verification
The bench targets the corner cases where a design could look right on a quick glance but still be wrong:
- Dual-channel chip-select on both channels, where a design ignoring `chan_b` would assert chip-select on channel A.
- Ultra2 writes, where a design reusing the legacy strobe would set bit `DATA_W` or leave the data on the port afterwards.
- Reads with `port_in` changing on every read cycle except the last, which exposes a design that samples too early.
- Step lengths of zero and above one.
- Requests and input changes injected mid-operation, which expose a design that restarts or re-reads its configuration.

// File: rtl/bctl_pkg.sv
package bctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_W1   = 3'd1,
        ST_W2   = 3'd2,
        ST_W3   = 3'd3,
        ST_W4   = 3'd4,
        ST_RD   = 3'd5
    } bctl_state_e;

    typedef enum logic [1:0] {
        VAR_LEGACY = 2'd0,
        VAR_DUAL   = 2'd1,
        VAR_U2     = 2'd2,
        VAR_ALT    = 2'd3
    } bctl_var_e;

endpackage

// File: rtl/bctl_step_timer.sv
module bctl_step_timer #(
    parameter int STEP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              run,
    input  logic [STEP_W-1:0] limit,
    output logic              last
);
    logic [STEP_W-1:0] cnt_q;
    logic [STEP_W-1:0] lim_eff;

    assign lim_eff = (limit == '0) ? STEP_W'(1) : limit;
    assign last    = run && (cnt_q == lim_eff - STEP_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (restart || last) cnt_q <= '0;
        else if (run)            cnt_q <= cnt_q + STEP_W'(1);
    end

    // R7
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < lim_eff));

endmodule

// File: rtl/bctl_pattern.sv
module bctl_pattern
    import bctl_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  bctl_state_e        state,
    input  bctl_var_e          var_sel,
    input  logic               chan_b,
    input  logic [DATA_W-1:0]  data,
    output logic [DATA_W+4:0]  value
);
    localparam int PW   = DATA_W + 5;
    localparam int B_ST = DATA_W;
    localparam int B_CS = DATA_W + 1;
    localparam int B_RE = DATA_W + 2;
    localparam int B_US = DATA_W + 3;
    localparam int B_UR = DATA_W + 4;

    logic [PW-1:0] dpart;
    logic [PW-1:0] stb;
    logic [PW-1:0] cs;
    logic          cs_on;

    assign dpart = {5'b0, data};
    assign stb   = PW'(1) << B_ST;
    assign cs_on = (var_sel == VAR_DUAL) ? chan_b : 1'b1;
    assign cs    = cs_on ? (PW'(1) << B_CS) : '0;

    always_comb begin
        value = '0;
        if (var_sel == VAR_U2) begin
            unique case (state)
                ST_W1:   value = '0;
                ST_W2:   value = dpart;
                ST_W3:   value = dpart | (PW'(1) << B_US);
                ST_W4:   value = '0;
                ST_RD:   value = PW'(1) << B_UR;
                default: value = '0;
            endcase
        end else begin
            unique case (state)
                ST_W1:   value = stb | cs;
                ST_W2:   value = stb | cs | dpart;
                ST_W3:   value = cs | dpart;
                ST_W4:   value = dpart;
                ST_RD:   value = (PW'(1) << B_RE) | cs;
                default: value = '0;
            endcase
        end
    end

endmodule

// File: rtl/bctl_seq.sv
module bctl_seq
    import bctl_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int STEP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic              rd_req,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        variant,
    input  logic              chan_b,
    input  logic [STEP_W-1:0] step_cycles,
    input  logic [DATA_W-1:0] port_in,
    output logic [DATA_W+4:0] port_q,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done
);
    localparam int PW   = DATA_W + 5;
    localparam int B_ST = DATA_W;
    localparam int B_CS = DATA_W + 1;

    bctl_state_e       state_q, state_n;
    bctl_var_e         var_q, var_sel;
    logic              chb_q, chb_sel;
    logic [DATA_W-1:0] data_q, data_sel;
    logic [STEP_W-1:0] lim_q;
    logic              start;
    logic              step_last;
    logic [PW-1:0]     pat;

    assign start    = (state_q == ST_IDLE) && (wr_req || rd_req);
    assign busy     = (state_q != ST_IDLE);
    assign var_sel  = start ? bctl_var_e'(variant) : var_q;
    assign chb_sel  = start ? chan_b : chb_q;
    assign data_sel = start ? wr_data : data_q;

    bctl_step_timer #(.STEP_W(STEP_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start),
        .run     (busy),
        .limit   (lim_q),
        .last    (step_last)
    );

    bctl_pattern #(.DATA_W(DATA_W)) u_pat (
        .state   (state_n),
        .var_sel (var_sel),
        .chan_b  (chb_sel),
        .data    (data_sel),
        .value   (pat)
    );

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_req)      state_n = ST_W1;
                else if (rd_req) state_n = ST_RD;
            end
            ST_W1: if (step_last) state_n = ST_W2;
            ST_W2: if (step_last) state_n = ST_W3;
            ST_W3: if (step_last) state_n = ST_W4;
            ST_W4: if (step_last) state_n = ST_IDLE;
            ST_RD: if (step_last) state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_q  <= '0;
            rd_data <= '0;
            done    <= 1'b0;
            var_q   <= VAR_LEGACY;
            chb_q   <= 1'b0;
            data_q  <= '0;
            lim_q   <= '0;
        end else begin
            if (start) begin
                var_q  <= bctl_var_e'(variant);
                chb_q  <= chan_b;
                data_q <= wr_data;
                lim_q  <= step_cycles;
            end
            done <= busy && (state_n == ST_IDLE);
            if (state_n != ST_IDLE)     port_q <= pat;
            else if (state_q == ST_RD)  port_q <= '0;
            if (state_q == ST_RD && step_last) rd_data <= port_in;
        end
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R6
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RD) |=> $stable(rd_data));

    // R6
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD && step_last) |=> (port_q == '0 && done));

    // R4
    u2_no_legacy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && var_q == VAR_U2) |-> (!port_q[B_ST] && !port_q[B_CS]));

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state_n != ST_IDLE) |=> ($stable(var_q) && $stable(data_q) && $stable(lim_q)));

endmodule

// File: tb/bctl_seq_tb.sv
`timescale 1ns/1ps
module bctl_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_req = 1'b0, rd_req = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  variant = '0;
    logic        chan_b = 1'b0;
    logic [3:0]  step_cycles = 4'd1;
    logic [7:0]  port_in = '0;
    logic [12:0] port_q;
    logic [7:0]  rd_data;
    logic        busy, done;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_rd = '0;

    always #2.5 clk = ~clk;

    bctl_seq u_dut (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_req(rd_req),
        .wr_data(wr_data), .variant(variant), .chan_b(chan_b),
        .step_cycles(step_cycles), .port_in(port_in),
        .port_q(port_q), .rd_data(rd_data), .busy(busy), .done(done)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected port value per step, from R2..R5
    function automatic logic [12:0] ref_val(bit rd, int step, int v, bit chb, logic [7:0] d);
        int acc;
        bit cs;
        cs = (v == 1) ? chb : 1'b1;
        acc = 0;
        if (rd) begin
            if (v == 2) acc = 'h1000;
            else        acc = 'h400 + (cs ? 'h200 : 0);
        end else if (v == 2) begin
            if (step == 1) acc = d;
            if (step == 2) acc = d + 'h800;
        end else begin
            acc = d;
            if (step == 0) acc = 0;
            if (step <= 1) acc += 'h100;
            if (step <= 2 && cs) acc += 'h200;
        end
        return 13'(acc);
    endfunction

    task automatic run_op(string tag, bit rd, bit both, logic [7:0] d, int v, bit chb,
                          int n, logic [7:0] in_b, bit poke);
        logic [12:0] q[$];
        logic [12:0] fin;
        int nn;
        int steps;
        nn = (n == 0) ? 1 : n;
        steps = rd ? 1 : 4;
        for (int s = 0; s < steps; s++)
            for (int c = 0; c < nn; c++) q.push_back(ref_val(rd, s, v, chb, d));
        fin = rd ? 13'h0 : q[q.size()-1];
        @(negedge clk);
        wr_req = !rd || both; rd_req = rd || both;
        wr_data = d; variant = 2'(v); chan_b = chb; step_cycles = 4'(n);
        port_in = ~in_b;
        @(negedge clk);
        wr_req = 0; rd_req = 0;
        wr_data = ~d; variant = 2'(v + 1); chan_b = ~chb; step_cycles = 4'(n + 2);
        for (int i = 0; i < q.size(); i++) begin
            chk({tag, " port (R2/R3/R4/R5/R7/R9)"}, 32'(port_q), 32'(q[i]));
            chk({tag, " busy R8"}, 32'({busy, done}), 32'h2);
            port_in = (i == q.size() - 1) ? in_b : ~in_b;
            if (poke && i == 1) begin wr_req = 1; rd_req = 1; end
            else begin wr_req = 0; rd_req = 0; end
            @(negedge clk);
        end
        wr_req = 0; rd_req = 0;
        if (rd) exp_rd = in_b;
        chk({tag, " done R8"}, 32'({busy, done}), 32'h1);
        chk({tag, " final port R6/R11"}, 32'(port_q), 32'(fin));
        chk({tag, " rd_data R6"}, 32'(rd_data), 32'(exp_rd));
        @(negedge clk);
        chk({tag, " idle after R9/R11"}, 32'({busy, done}), 32'h0);
        chk({tag, " hold R11"}, 32'(port_q), 32'(fin));
        chk({tag, " rd hold R6"}, 32'(rd_data), 32'(exp_rd));
    endtask

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 port", 32'(port_q), 0);
        chk("R1 rd_data", 32'(rd_data), 0);
        chk("R1 flags", 32'({busy, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_op("R2 legacy wr", 0, 0, 8'hA5, 0, 0, 1, 8'h00, 0);
        run_op("R2 legacy wr n3 R7", 0, 0, 8'h3C, 0, 1, 3, 8'h00, 0);
        run_op("R3 dual wr chA", 0, 0, 8'h5A, 1, 0, 2, 8'h00, 0);
        run_op("R3 dual wr chB", 0, 0, 8'hC3, 1, 1, 1, 8'h00, 0);
        run_op("R4 u2 wr", 0, 0, 8'hFF, 2, 1, 2, 8'h00, 0);
        run_op("R5 legacy rd", 1, 0, 8'h00, 0, 0, 3, 8'h96, 0);
        run_op("R5 dual rd chA", 1, 0, 8'h00, 1, 0, 1, 8'h17, 0);
        run_op("R5 dual rd chB", 1, 0, 8'h00, 1, 1, 2, 8'h28, 0);
        run_op("R5 u2 rd", 1, 0, 8'h00, 2, 0, 4, 8'hE1, 0);
        run_op("R7 zero step", 0, 0, 8'h81, 0, 0, 0, 8'h00, 0);
        run_op("R9 poke wr", 0, 0, 8'h42, 1, 1, 2, 8'h00, 1);
        run_op("R9 poke rd", 1, 0, 8'h00, 0, 0, 3, 8'h6B, 1);
        run_op("R10 both", 0, 1, 8'h99, 0, 0, 1, 8'h00, 0);
        run_op("R10 code3", 0, 0, 8'h0F, 3, 0, 2, 8'h00, 0);
        run_op("R10 code3 rd", 1, 0, 8'h00, 3, 0, 1, 8'hD2, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule